// File: doc/BRIEF.md
# Free-Running Timer with Compare and Capture

This block is a 16-bit up-counter that never stops on its own. Software reaches it through an 8-bit register port. The counter advances on a counting pulse. A two-bit select field picks the source of that pulse: one of three internal divided-down clock rates, or the rising edge of an external clock pin.

Two compare words raise match flags. Compare word A can also send the counter back to zero. A capture pin loads the current count into a read-only capture word, on the edge polarity that software selects. The counter wrapping past its top value raises an overflow flag. A single interrupt line reports any flag whose enable bit is set.

The 16-bit words are reached one byte at a time through one shared byte latch, so software always sees or loads a whole word. The register port is a plain strobe interface, not a stream. Every read or write completes in the cycle its strobe is high, so there is no back-pressure and no wait state. Read data is combinational, and it is driven only while the read strobe is high.

Top module: `frt_timer`

## Requirements
- R1: After reset, the control byte, the status byte and the counter read 0x00, both compare words read 0xFFFF, and the capture word reads 0x0000.
- R2: Offsets 0 to 9 hold, in order: control, status, counter high and low, compare A high and low, compare B high and low, capture high and low. Offsets 10 to 15 read 0x00, and the read data is 0x00 whenever the read strobe is low.
- R3: Control bits 1:0 pick the counting pulse. A divider starts at zero at reset and counts every clock. Settings 0, 1 and 2 give a pulse when the divider value modulo 2, 8 or 32 equals that modulus minus one. Setting 3 gives a pulse on each rising edge of the external clock, seen after a two-flop synchronizer.
- R4: The counter goes up by one on each counting pulse and otherwise holds its value.
- R5: A counting pulse at 0xFFFF takes the counter to 0x0000 and sets the overflow flag (status bit 4).
- R6: A counting pulse while the counter equals compare A sets status bit 6. A counting pulse while it equals compare B sets status bit 5.
- R7: With control bit 2 set, a counting pulse that matches compare A loads zero instead of counting up. That case does not set the overflow flag.
- R8: A capture-pin edge, seen after a two-flop synchronizer, copies the counter into the capture word and sets status bit 7. Control bit 3 chooses the edge: 1 for rising, 0 for falling. Writes to offsets 8 and 9 are ignored.
- R9: A status write clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. A flag raised in the same cycle as a clearing write stays set. Status bits 3:0 read 0.
- R10: Reading a high byte returns that word's upper byte and copies its lower byte into the shared latch. A later low-byte read returns the latched byte, even if the word has changed since.
- R11: Writing a high byte loads the shared latch. A later low-byte write loads the whole word {latch, data} in one cycle. For the counter, that load takes priority over counting.
- R12: Control bits 7, 6, 5 and 4 enable status bits 7, 6, 5 and 4. The interrupt output is high exactly while some flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| ext_clk_in | input | 1 | External counting clock, asynchronous |
| capture_in | input | 1 | Capture trigger pin, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these rules:
- the counter holds between counting pulses;
- a compare-A clear lands on zero;
- the overflow flag rises only after a pulse at the top count;
- the capture word moves only on a capture edge;
- the read data is quiet without a read strobe;
- no interrupt is raised while all flags are clear.

Only the bench's scenarios can show the rest:
- the divider spacing of each clock setting;
- that the byte latch keeps a low byte while the counter moves on;
- the edge polarity choice;
- the write-zero-only clearing of the flags;
- the exact counts the register port returns.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 2 * BUS_W;
  localparam int NFLAG  = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_WLO  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_WHI  = 4'd9;

  typedef struct packed {
    logic cap;
    logic cma;
    logic cmb;
    logic ovf;
  } flags_t;

  typedef struct packed {
    flags_t     ien;
    logic       cap_rise;
    logic       clr_on_a;
    logic [1:0] src;
  } ctrl_t;
endpackage

// File: rtl/frt_sync_edge.sv
module frt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic want_rise,
  output logic hit
);
  logic [STAGES-1:0] shreg;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      last  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], pin};
      last  <= shreg[STAGES-1];
    end
  end

  assign hit = want_rise ? (shreg[STAGES-1] & ~last) : (~shreg[STAGES-1] & last);
endmodule

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int SH0 = 1,
  parameter int SH1 = 3,
  parameter int SH2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src,
  input  logic       ext_edge,
  output logic       tick
);
  localparam int DIV_W = SH2;
  localparam int NTAP  = 3;

  logic [DIV_W-1:0] div;
  logic [3:0]       taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int SH = (g == 0) ? SH0 : (g == 1) ? SH1 : SH2;
    localparam logic [DIV_W-1:0] MASK = DIV_W'((1 << SH) - 1);
    assign taps[g] = (div & MASK) == MASK;
  end

  assign taps[3] = ext_edge;
  assign tick    = taps[src];
endmodule

// File: rtl/frt_core.sv
module frt_core
  import frt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cap_edge,
  input  logic             stat_wr,
  input  logic [NFLAG-1:0] stat_keep,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap,
  output flags_t           flags
);
  logic   match_a, match_b, zero_load, wrap;
  flags_t set_now;

  assign match_a   = tick && (cnt == cmpa);
  assign match_b   = tick && (cnt == cmpb);
  assign zero_load = match_a && ctrl.clr_on_a;
  assign wrap      = tick && !zero_load && (&cnt);
  assign set_now   = '{cap: cap_edge, cma: match_a, cmb: match_b, ovf: wrap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cap   <= '0;
      flags <= '0;
    end else begin
      if (cnt_wr)         cnt <= cnt_wdata;
      else if (zero_load) cnt <= '0;
      else if (tick)      cnt <= cnt + 1'b1;
      if (cap_edge)       cap <= cnt;
      flags <= (stat_wr ? (flags & stat_keep) : flags) | set_now;
    end
  end
endmodule

// File: rtl/frt_regif.sv
module frt_regif
  import frt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cap,
  input  flags_t            flags,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  cmpa,
  output logic [CNT_W-1:0]  cmpb,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              stat_wr,
  output logic [NFLAG-1:0]  stat_keep
);
  localparam int NWORD = 4;
  localparam int NCMP  = 2;
  localparam logic [1:0] CAP_IDX = 2'd3;

  logic [BUS_W-1:0] hold;
  logic [CNT_W-1:0] words [NWORD];
  logic [CNT_W-1:0] cmp_q [NCMP];
  logic             in_word, hi, wr_ok;
  logic [2:0]       pair;
  logic [1:0]       widx;

  assign in_word = (bus_addr >= OFS_WLO) && (bus_addr <= OFS_WHI);
  assign pair    = bus_addr[3:1] - 3'd1;
  assign widx    = pair[1:0];
  assign hi      = !bus_addr[0];
  assign wr_ok   = bus_wr && in_word && (widx != CAP_IDX);

  assign words[0] = cnt;
  assign words[1] = cmp_q[0];
  assign words[2] = cmp_q[1];
  assign words[3] = cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      ctrl <= '0;
    end else begin
      if (wr_ok && hi)                    hold <= bus_wdata;
      else if (bus_rd && in_word && hi)   hold <= words[widx][BUS_W-1:0];
      if (bus_wr && bus_addr == OFS_CTRL) ctrl <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q[g] <= '1;
      else if (wr_ok && !hi && widx == 2'(g + 1)) cmp_q[g] <= {hold, bus_wdata};
    end
  end

  assign cmpa      = cmp_q[0];
  assign cmpb      = cmp_q[1];
  assign cnt_wr    = wr_ok && !hi && (widx == 2'd0);
  assign cnt_wdata = {hold, bus_wdata};
  assign stat_wr   = bus_wr && (bus_addr == OFS_STAT);
  assign stat_keep = bus_wdata[BUS_W-1 -: NFLAG];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == OFS_CTRL)      bus_rdata = ctrl;
      else if (bus_addr == OFS_STAT) bus_rdata = {flags, {(BUS_W-NFLAG){1'b0}}};
      else if (in_word)              bus_rdata = hi ? words[widx][CNT_W-1 -: BUS_W] : hold;
    end
  end
endmodule

// File: rtl/frt_timer.sv
module frt_timer
  import frt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ext_clk_in,
  input  logic              capture_in,
  output logic              irq
);
  ctrl_t            ctrl;
  flags_t           flags;
  logic [CNT_W-1:0] cnt, cap, cmpa, cmpb, cnt_wdata;
  logic [NFLAG-1:0] stat_keep;
  logic             cnt_wr, stat_wr, ext_edge, cap_edge, tick;

  frt_sync_edge #(.STAGES(2)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk_in), .want_rise(1'b1), .hit(ext_edge));

  frt_sync_edge #(.STAGES(2)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .pin(capture_in), .want_rise(ctrl.cap_rise), .hit(cap_edge));

  frt_prescaler #(.SH0(1), .SH1(3), .SH2(5)) u_presc (
    .clk(clk), .rst_n(rst_n), .src(ctrl.src), .ext_edge(ext_edge), .tick(tick));

  frt_regif u_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .cap(cap), .flags(flags),
    .ctrl(ctrl), .cmpa(cmpa), .cmpb(cmpb), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .stat_wr(stat_wr), .stat_keep(stat_keep));

  frt_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl), .cmpa(cmpa), .cmpb(cmpb),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cap_edge(cap_edge), .stat_wr(stat_wr),
    .stat_keep(stat_keep), .cnt(cnt), .cap(cap), .flags(flags));

  assign irq = |(flags & ctrl.ien);
endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic        tick,
  input logic        cnt_wr,
  input logic        clr_on_a,
  input logic [15:0] cnt,
  input logic [15:0] cmpa,
  input logic [15:0] cap,
  input logic        cap_edge,
  input logic [3:0]  flags,
  input logic        irq
);
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !tick) |=> $stable(cnt));

  // R7
  cmpa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && tick && clr_on_a && cnt == cmpa) |=> (cnt == 16'h0000));

  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(tick && cnt == 16'hFFFF));

  // R8
  cap_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_edge |=> $stable(cap));

  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 4'h0) |-> !irq);
endmodule

bind frt_timer frt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tick(tick),
  .cnt_wr(cnt_wr), .clr_on_a(ctrl.clr_on_a), .cnt(cnt), .cmpa(cmpa), .cap(cap),
  .cap_edge(cap_edge), .flags(flags), .irq(irq));

// File: tb/test_frt_timer.sv
`timescale 1ns/100ps
module test_frt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk_in = 1'b0, capture_in = 1'b0;
  logic       irq;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  frt_timer i_frt_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
    .capture_in(capture_in), .irq(irq));

  // behavioural reference state
  logic [15:0] m_cnt, m_cmpa, m_cmpb, m_cap;
  logic [7:0]  m_ctrl, m_tmp;
  logic [3:0]  m_flg;
  int          m_div;
  logic        e1, e2, ep, c1, c2, cp;

  always @(posedge clk) begin : model
    int n;
    bit tk, ma, mb, clr, wrap, ced;
    logic [15:0] nxt;
    if (!rst_n) begin
      m_cnt = 0; m_cmpa = 16'hFFFF; m_cmpb = 16'hFFFF; m_cap = 0;
      m_ctrl = 0; m_tmp = 0; m_flg = 0; m_div = 0;
      e1 = 0; e2 = 0; ep = 0; c1 = 0; c2 = 0; cp = 0;
    end else begin
      case (m_ctrl[1:0])
        2'd0: n = 2;
        2'd1: n = 8;
        2'd2: n = 32;
        default: n = 0;
      endcase
      tk   = (n == 0) ? (e2 && !ep) : ((m_div % n) == n - 1);
      ma   = tk && (m_cnt == m_cmpa);
      mb   = tk && (m_cnt == m_cmpb);
      clr  = ma && m_ctrl[2];
      wrap = tk && !clr && (m_cnt == 16'hFFFF);
      ced  = m_ctrl[3] ? (c2 && !cp) : (!c2 && cp);
      nxt  = clr ? 16'h0 : (tk ? m_cnt + 16'h1 : m_cnt);
      if (bus_wr) begin
        case (bus_addr)
          4'd0: m_ctrl = bus_wdata;
          4'd1: m_flg = m_flg & bus_wdata[7:4];
          4'd2, 4'd4, 4'd6: m_tmp = bus_wdata;
          4'd3: nxt = {m_tmp, bus_wdata};
          4'd5: m_cmpa = {m_tmp, bus_wdata};
          4'd7: m_cmpb = {m_tmp, bus_wdata};
          default: ;
        endcase
      end else if (bus_rd) begin
        case (bus_addr)
          4'd2: m_tmp = m_cnt[7:0];
          4'd4: m_tmp = m_cmpa[7:0];
          4'd6: m_tmp = m_cmpb[7:0];
          4'd8: m_tmp = m_cap[7:0];
          default: ;
        endcase
      end
      if (ced) m_cap = m_cnt;
      m_flg = m_flg | {ced, ma, mb, wrap};
      m_cnt = nxt;
      m_div = (m_div + 1) % 32;
      ep = e2; e2 = e1; e1 = ext_clk_in;
      cp = c2; c2 = c1; c1 = capture_in;
    end
  end

  function automatic logic [7:0] exp_rdata();
    if (!bus_rd) return 8'h00;
    case (bus_addr)
      4'd0: return m_ctrl;
      4'd1: return {m_flg, 4'h0};
      4'd2: return m_cnt[15:8];
      4'd4: return m_cmpa[15:8];
      4'd6: return m_cmpb[15:8];
      4'd8: return m_cap[15:8];
      4'd3, 4'd5, 4'd7, 4'd9: return m_tmp;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare against the reference every cycle, one ns before the rising edge
  always begin
    @(negedge clk);
    #1.5;
    if (rst_n && !done) begin
      chk(bus_rdata == exp_rdata(), "R2 R10 cycle rdata", bus_rdata, exp_rdata());
      chk(irq == |(m_flg & m_ctrl[7:4]), "R12 cycle irq", irq, |(m_flg & m_ctrl[7:4]));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1; d = bus_rdata;
    @(posedge clk); #1; bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] d);
    wr(a, d[15:8]); wr(a + 4'd1, d[7:0]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] h, l;
    rd(a, h); rd(a + 4'd1, l); d = {h, l};
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_clk_in = 1'b1; repeat (3) @(negedge clk);
    ext_clk_in = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic cap_pulse();
    @(negedge clk); capture_in = 1'b1; repeat (3) @(negedge clk);
    capture_in = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0]  v8;
    logic [15:0] v16;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(4'd0, v8);  chk(v8 == 8'h00, "R1 ctrl", v8, 8'h00);
    rd(4'd1, v8);  chk(v8 == 8'h00, "R1 status", v8, 8'h00);
    rd(4'd2, v8);  chk(v8 == 8'h00, "R1 counter high", v8, 8'h00);
    rd16(4'd4, v16); chk(v16 == 16'hFFFF, "R1 compare A", v16, 16'hFFFF);
    rd16(4'd6, v16); chk(v16 == 16'hFFFF, "R1 compare B", v16, 16'hFFFF);
    rd16(4'd8, v16); chk(v16 == 16'h0000, "R1 capture", v16, 16'h0000);
    rd(4'd12, v8); chk(v8 == 8'h00, "R2 unused offset", v8, 8'h00);
    // R11 word write, external source holds the counter still
    wr(4'd0, 8'h03);
    wr16(4'd2, 16'h1234);
    rd16(4'd2, v16); chk(v16 == 16'h1234, "R11 counter load", v16, 16'h1234);
    // R10 low byte stays latched while the counter moves
    rd(4'd2, v8);
    ext_pulse();
    rd(4'd3, v8); chk(v8 == 8'h34, "R10 latched low byte", v8, 8'h34);
    rd16(4'd2, v16); chk(v16 == 16'h1235, "R3 external edge count", v16, 16'h1235);
    // R6 compare A flag
    wr16(4'd4, 16'h1237);
    repeat (3) ext_pulse();
    rd(4'd1, v8); chk(v8 == 8'h40, "R6 compare A flag", v8, 8'h40);
    rd16(4'd2, v16); chk(v16 == 16'h1238, "R4 count after match", v16, 16'h1238);
    // R9 write-zero-only clearing
    wr(4'd1, 8'hF0);
    rd(4'd1, v8); chk(v8 == 8'h40, "R9 ones keep flags", v8, 8'h40);
    wr(4'd1, 8'hBF);
    rd(4'd1, v8); chk(v8 == 8'h00, "R9 zero clears flag", v8, 8'h00);
    // R7 clear on compare A
    wr(4'd0, 8'h07);
    wr16(4'd2, 16'h1236);
    ext_pulse(); ext_pulse();
    rd16(4'd2, v16); chk(v16 == 16'h0000, "R7 cleared by match", v16, 16'h0000);
    rd(4'd1, v8); chk(v8 == 8'h40, "R7 match flag", v8, 8'h40);
    wr(4'd1, 8'h00);
    // R6 compare B flag
    wr(4'd0, 8'h03);
    wr16(4'd6, 16'h0001);
    ext_pulse(); ext_pulse();
    rd(4'd1, v8); chk(v8 == 8'h20, "R6 compare B flag", v8, 8'h20);
    rd16(4'd2, v16); chk(v16 == 16'h0002, "R4 count past B", v16, 16'h0002);
    wr(4'd1, 8'h00);
    // R5 overflow
    wr16(4'd2, 16'hFFFF);
    ext_pulse();
    rd16(4'd2, v16); chk(v16 == 16'h0000, "R5 wrap to zero", v16, 16'h0000);
    rd(4'd1, v8); chk(v8 == 8'h10, "R5 overflow flag", v8, 8'h10);
    wr(4'd1, 8'h00);
    // R7 match clear at the top value does not flag overflow
    wr(4'd0, 8'h07);
    wr16(4'd4, 16'hFFFF);
    wr16(4'd2, 16'hFFFF);
    ext_pulse();
    rd(4'd1, v8); chk(v8 == 8'h40, "R7 no overflow on clear", v8, 8'h40);
    wr(4'd1, 8'h00);
    // R8 capture, rising then falling polarity
    wr(4'd0, 8'h0B);
    wr16(4'd2, 16'h00AB);
    cap_pulse();
    rd16(4'd8, v16); chk(v16 == 16'h00AB, "R8 rising capture", v16, 16'h00AB);
    rd(4'd1, v8); chk(v8 == 8'h80, "R8 capture flag", v8, 8'h80);
    wr(4'd0, 8'h03);
    wr(4'd1, 8'h00);
    wr16(4'd2, 16'h0CD0);
    cap_pulse();
    rd16(4'd8, v16); chk(v16 == 16'h0CD0, "R8 falling capture", v16, 16'h0CD0);
    wr(4'd8, 8'h55); wr(4'd9, 8'h66);
    rd16(4'd8, v16); chk(v16 == 16'h0CD0, "R8 capture read-only", v16, 16'h0CD0);
    // R12 interrupt enable
    chk(irq == 1'b0, "R12 disabled flag", irq, 0);
    wr(4'd0, 8'h83);
    chk(irq == 1'b1, "R12 enabled flag", irq, 1);
    wr(4'd1, 8'h7F);
    chk(irq == 1'b0, "R12 flag cleared", irq, 0);
    // R3 internal rates
    wr(4'd0, 8'h00); wr16(4'd2, 16'h0000);
    repeat (64) @(negedge clk);
    rd16(4'd2, v16); chk(v16 >= 31 && v16 <= 35, "R3 rate /2", v16, 33);
    wr(4'd0, 8'h01); wr16(4'd2, 16'h0000);
    repeat (64) @(negedge clk);
    rd16(4'd2, v16); chk(v16 >= 7 && v16 <= 10, "R3 rate /8", v16, 8);
    wr(4'd0, 8'h02); wr16(4'd2, 16'h0000);
    repeat (128) @(negedge clk);
    rd16(4'd2, v16); chk(v16 >= 3 && v16 <= 5, "R3 rate /32", v16, 4);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule